// File: doc/BRIEF.md
# SDRAM Burst Data Path

This block is the column and data side of a single-data-rate SDRAM device model. It keeps the programmed read latency, burst length, burst ordering and write-burst mode. From decoded read, write and burst-stop strobes and a start column it produces one column address per clock. Write beats go straight into a memory-array port. Read beats come back from that port and travel through a latency pipeline to the DQ output, qualified by an output-enable.

The DQ mask input acts differently in the two directions. During a write it suppresses the array write in the same cycle. During a read it blanks the output two cycles later, whatever latency is programmed. Row activation, refresh and electrical timing are handled elsewhere. The memory array answers reads combinationally from `mem_addr`.

Top module: `sdr_data_path`

## Requirements
- R1: While `rst_n` is low and after its release, `dq_oe`, `dq_out` and `mem_we` are 0. The mode reverts to latency 3, burst length 1, sequential ordering and burst writes.
- R2: A clock edge with `mode_load` high loads the mode, which applies from the next cycle. `mode_cl` = 2 selects latency 2 and every other value selects 3. `mode_bl` codes 0, 1, 2 and 3 give 1, 2, 4 and 8 beats, code 7 gives full page, and codes 4 to 6 give 1 beat.
- R3: A read beat issued in cycle c (the command cycle is beat 0, then one beat per following cycle) appears on `dq_out` with `dq_oe` high in cycle c+CL.
- R4: A write places beat 0 in the command cycle and the next beats in the following cycles. On each beat `mem_we` is 1, `mem_addr` holds the beat column and `mem_wdata` equals `dq_in` of that cycle.
- R5: `dqm` high in a write-beat cycle drops `mem_we` in that same cycle. The burst still advances.
- R6: `dqm` sampled high in cycle d forces `dq_oe` low and `dq_out` to 0 in cycle d+2.
- R7: Sequential ordering, for burst length 2^n: beat k keeps the start column's upper bits, and its low n bits are (start + k) mod 2^n.
- R8: Interleaved ordering (`mode_ilv` = 1): beat k keeps the upper bits, and its low n bits are start XOR k.
- R9: Full page ignores `mode_ilv`. Beat k is (start + k) mod 512, and the burst keeps running until a stop or a new command.
- R10: A cycle with `cmd_stop` high issues no beat and ends the burst. It takes priority over `cmd_rd` and `cmd_wr` in the same cycle.
- R11: A read or write in any cycle, including back-to-back cycles, cuts off the running burst and starts its own at beat 0. `cmd_wr` wins over `cmd_rd`.
- R12: With `mode_single_wr` = 1 a write transfers only beat 0. Reads still use the programmed length.
- R13: `dq_out` is 0 whenever `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Load the mode fields below |
| mode_cl | input | 2 | Read latency code (2 gives 2, else 3) |
| mode_bl | input | 3 | Burst length code |
| mode_ilv | input | 1 | 1 selects interleaved ordering |
| mode_single_wr | input | 1 | 1 limits writes to a single beat |
| cmd_rd | input | 1 | Decoded read command |
| cmd_wr | input | 1 | Decoded write command |
| cmd_stop | input | 1 | Decoded burst-stop command |
| col_start | input | COL_W | Start column of the command |
| dqm | input | 1 | Data mask pin |
| dq_in | input | DQ_W | Write data from the DQ pins |
| mem_rdata | input | DQ_W | Array read data for `mem_addr` |
| mem_addr | output | COL_W | Column of the current beat |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | DQ_W | Array write data |
| dq_out | output | DQ_W | Read data toward the DQ pins |
| dq_oe | output | 1 | DQ output enable |

## Verification
Reads are swept over both latencies, the four fixed lengths, both orderings, and start columns with zero, mixed and all-ones low bits. Because every array word encodes its own column, each output beat shows both its ordering and its latency. Writes are swept the same way with one masked beat, which separates a same-cycle mask from a delayed one. Directed patterns cover full-page wrap past column 511 with a stop, a read mask that lands on an in-flight beat, a read cut off by a second read, back-to-back writes, stop colliding with a write, reserved length and latency codes, and single-write mode followed by a full-length read.

// File: rtl/sdr_dp_pkg.sv
package sdr_dp_pkg;

  typedef struct packed {
    logic       cl3;        // 1: latency 3, 0: latency 2
    logic [2:0] blc;        // burst length code
    logic       ilv;        // interleaved ordering
    logic       wr_single;  // single-beat writes
  } dp_mode_t;

  localparam logic [2:0] BLC_FULL = 3'd7;
  localparam dp_mode_t   MODE_RST = '{cl3: 1'b1, blc: 3'd0, ilv: 1'b0, wr_single: 1'b0};

  // log2 of the burst length for the fixed codes; reserved codes give one beat
  function automatic logic [1:0] blc_log2(input logic [2:0] code);
    return code[2] ? 2'd0 : code[1:0];
  endfunction

endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
  import sdr_dp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  logic [1:0] cl_code,
  input  logic [2:0] bl_code,
  input  logic     ilv,
  input  logic     single_wr,
  output dp_mode_t mode
);

  dp_mode_t mode_q, mode_n;

  always_comb begin
    mode_n.cl3       = (cl_code != 2'd2);
    mode_n.blc       = bl_code;
    mode_n.ilv       = ilv;
    mode_n.wr_single = single_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= MODE_RST;
    else if (load) mode_q <= mode_n;
  end

  assign mode = mode_q;

endmodule

// File: rtl/sdr_burst_gen.sv
module sdr_burst_gen
  import sdr_dp_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dp_mode_t         mode,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_stop,
  input  logic [COL_W-1:0] col_start,
  output logic             beat_vld,
  output logic             beat_wr,
  output logic [COL_W-1:0] beat_addr
);

  localparam logic [COL_W-1:0] ONES = '1;
  localparam logic [COL_W-1:0] ONE  = COL_W'(1);

  logic             act_q, act_n, wr_q, wr_n, upd_en;
  logic [COL_W-1:0] base_q, base_n, cnt_q, cnt_n;
  logic             full, start;
  logic [COL_W-1:0] lowm, cur_base, cur_cnt, seq_a, ilv_a;

  // address of the beat issued in this cycle
  always_comb begin
    full     = (mode.blc == BLC_FULL);
    lowm     = ~(ONES << blc_log2(mode.blc));
    start    = !cmd_stop && (cmd_rd || cmd_wr);
    cur_base = start ? col_start : base_q;
    cur_cnt  = start ? '0 : cnt_q;
    seq_a    = cur_base + cur_cnt;
    ilv_a    = cur_base ^ cur_cnt;
    if (full)          beat_addr = seq_a;
    else if (mode.ilv) beat_addr = (cur_base & ~lowm) | (ilv_a & lowm);
    else               beat_addr = (cur_base & ~lowm) | (seq_a & lowm);
    beat_vld = !cmd_stop && (start || act_q);
    beat_wr  = start ? cmd_wr : wr_q;
  end

  // burst continuation state
  always_comb begin
    act_n  = act_q;
    wr_n   = wr_q;
    base_n = base_q;
    cnt_n  = cnt_q;
    upd_en = cmd_stop || start || act_q;
    if (cmd_stop) begin
      act_n = 1'b0;
    end else if (start) begin
      act_n  = !(cmd_wr && mode.wr_single) && (full || (lowm != '0));
      wr_n   = cmd_wr;
      base_n = col_start;
      cnt_n  = ONE;
    end else if (act_q) begin
      act_n = full || (cnt_q != lowm);
      cnt_n = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
    end else if (upd_en) begin
      act_q <= act_n;
      wr_q  <= wr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      base_q <= base_n;
      cnt_q  <= cnt_n;
    end
  end

endmodule

// File: rtl/sdr_dq_pipe.sv
module sdr_dq_pipe #(
  parameter int DQ_W     = 16,
  parameter int MAX_CL   = 3,
  parameter int MASK_LAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lat_long,
  input  logic            rd_vld,
  input  logic [DQ_W-1:0] rd_data,
  input  logic            dqm,
  output logic [DQ_W-1:0] dq_out,
  output logic            dq_oe
);

  localparam int TAP_L = MAX_CL - 1;
  localparam int TAP_S = MAX_CL - 2;

  logic [MAX_CL-1:0]   vld_q, vld_n;
  logic [MASK_LAT-1:0] msk_q, msk_n;
  logic [DQ_W-1:0]     dat_q [MAX_CL];
  logic                tap_vld;
  logic [DQ_W-1:0]     tap_dat;

  always_comb begin
    vld_n = {vld_q[MAX_CL-2:0], rd_vld};
    msk_n = {msk_q[MASK_LAT-2:0], dqm};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      msk_q <= '0;
    end else begin
      vld_q <= vld_n;
      msk_q <= msk_n;
    end
  end

  for (genvar i = 0; i < MAX_CL; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) if (rd_vld) dat_q[0] <= rd_data;
    end else begin : g_body
      always_ff @(posedge clk) if (vld_q[i-1]) dat_q[i] <= dat_q[i-1];
    end
  end

  always_comb begin
    tap_vld = lat_long ? vld_q[TAP_L] : vld_q[TAP_S];
    tap_dat = lat_long ? dat_q[TAP_L] : dat_q[TAP_S];
    dq_oe   = tap_vld && !msk_q[MASK_LAT-1];
    dq_out  = dq_oe ? tap_dat : '0;
  end

endmodule

// File: rtl/sdr_data_path.sv
module sdr_data_path
  import sdr_dp_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int DQ_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [1:0]       mode_cl,
  input  logic [2:0]       mode_bl,
  input  logic             mode_ilv,
  input  logic             mode_single_wr,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_stop,
  input  logic [COL_W-1:0] col_start,
  input  logic             dqm,
  input  logic [DQ_W-1:0]  dq_in,
  input  logic [DQ_W-1:0]  mem_rdata,
  output logic [COL_W-1:0] mem_addr,
  output logic             mem_we,
  output logic [DQ_W-1:0]  mem_wdata,
  output logic [DQ_W-1:0]  dq_out,
  output logic             dq_oe
);

  dp_mode_t mode;
  logic     beat_vld, beat_wr, rd_beat;

  sdr_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (mode_load),
    .cl_code   (mode_cl),
    .bl_code   (mode_bl),
    .ilv       (mode_ilv),
    .single_wr (mode_single_wr),
    .mode      (mode)
  );

  sdr_burst_gen #(.COL_W(COL_W)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .cmd_rd    (cmd_rd),
    .cmd_wr    (cmd_wr),
    .cmd_stop  (cmd_stop),
    .col_start (col_start),
    .beat_vld  (beat_vld),
    .beat_wr   (beat_wr),
    .beat_addr (mem_addr)
  );

  // write mask acts in the beat's own cycle
  assign rd_beat   = beat_vld && !beat_wr;
  assign mem_we    = beat_vld && beat_wr && !dqm;
  assign mem_wdata = dq_in;

  sdr_dq_pipe #(.DQ_W(DQ_W)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .lat_long (mode.cl3),
    .rd_vld   (rd_beat),
    .rd_data  (mem_rdata),
    .dqm      (dqm),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );

endmodule

// File: rtl/sdr_data_path_chk.sv
module sdr_data_path_chk #(
  parameter int COL_W = 9,
  parameter int DQ_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dqm,
  input logic             cmd_wr,
  input logic             cmd_stop,
  input logic [COL_W-1:0] col_start,
  input logic             mem_we,
  input logic [COL_W-1:0] mem_addr,
  input logic             dq_oe,
  input logic [DQ_W-1:0]  dq_out,
  input logic             rd_beat
);

  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age <= 2'd0;
    else if (age != 2'd3)  age <= age + 2'd1;
  end

  p_wr_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dqm |-> !mem_we);

  p_rd_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(dqm, 2)) |-> !dq_oe);

  p_stop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |-> !mem_we);

  p_rd_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && dq_oe) |-> ($past(rd_beat, 2) || $past(rd_beat, 3)));

  p_wr_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_stop && !dqm) |-> (mem_we && mem_addr == col_start));

  p_idle_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));

endmodule

bind sdr_data_path sdr_data_path_chk #(.COL_W(COL_W), .DQ_W(DQ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dqm       (dqm),
  .cmd_wr    (cmd_wr),
  .cmd_stop  (cmd_stop),
  .col_start (col_start),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .dq_oe     (dq_oe),
  .dq_out    (dq_out),
  .rd_beat   (rd_beat)
);

// File: tb/sim_sdr_data_path.sv
`timescale 1ns/1ps
module sim_sdr_data_path;

  localparam int COL_W = 9;
  localparam int DQ_W  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic mode_load, mode_ilv, mode_single_wr;
  logic [1:0] mode_cl;
  logic [2:0] mode_bl;
  logic cmd_rd, cmd_wr, cmd_stop, dqm;
  logic [COL_W-1:0] col_start, mem_addr;
  logic [DQ_W-1:0]  dq_in, mem_rdata, mem_wdata, dq_out;
  logic mem_we, dq_oe;

  logic [DQ_W-1:0] mem [512];

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sdr_data_path #(.COL_W(COL_W), .DQ_W(DQ_W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_cl(mode_cl),
    .mode_bl(mode_bl), .mode_ilv(mode_ilv), .mode_single_wr(mode_single_wr),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_stop(cmd_stop), .col_start(col_start),
    .dqm(dqm), .dq_in(dq_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic init_mem();
    for (int i = 0; i < 512; i++) mem[i] = 16'hC000 | 16'(i);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cmd_rd = 0; cmd_wr = 0; cmd_stop = 0; dqm = 0; dq_in = '0; mode_load = 0;
  endtask

  task automatic next();
    @(posedge clk); #1;
  endtask

  task automatic set_mode(input int clc, input int blc, input int ilv, input int sgl);
    mode_load = 1; mode_cl = 2'(clc); mode_bl = 3'(blc);
    mode_ilv = ilv[0]; mode_single_wr = sgl[0];
    next();
    mode_load = 0;
  endtask

  function automatic int exp_addr(int b, int k, int lg, bit full, bit ilv);
    int m = (1 << lg) - 1;
    if (full) return (b + k) % 512;
    return (b & ~m) | ((ilv ? (b ^ k) : (b + k)) & m);
  endfunction

  // read with optional mask, stop and second read, offsets from the command cycle
  task automatic rd_case(input bit ld, input int clc, input int blc, input int ilv, input int sgl,
                         input int st, input int dqm_at, input int stop_at,
                         input int rd2_at, input int st2, input string req);
    int iv [24];
    int ia [24];
    int lat  = (clc == 2) ? 2 : 3;
    int lg   = (blc <= 3) ? blc : 0;
    bit full = (blc == 7);
    int len  = 1 << lg;
    int base = 0;
    int k    = 0;
    bit act  = 0;
    bit ev;
    logic [DQ_W-1:0] ed;
    if (ld) set_mode(clc, blc, ilv, sgl);
    for (int i = 0; i < 24; i++) begin
      iv[i] = 0; ia[i] = 0;
      if (i == stop_at) act = 0;
      else begin
        if (i == 0 || i == rd2_at) begin base = (i == 0) ? st : st2; k = 0; act = 1; end
        if (act) begin
          iv[i] = 1; ia[i] = exp_addr(base, k, lg, full, ilv[0]); k++;
          if (!full && k == len) act = 0;
        end
      end
    end
    for (int j = 0; j < 24; j++) begin
      cmd_rd    = (j == 0) || (j == rd2_at);
      cmd_stop  = (j == stop_at);
      col_start = COL_W'((j == rd2_at) ? st2 : st);
      dqm       = (j == dqm_at);
      #2;
      ev = (j >= lat) && (iv[j-lat] != 0) && !(dqm_at >= 0 && j - 2 == dqm_at);
      ed = ev ? (16'hC000 | 16'(ia[j-lat])) : '0;
      chk({dq_oe, dq_out} == {ev, ed}, req, {15'd0, dq_oe, dq_out}, {15'd0, ev, ed});
      next();
      idle();
    end
  endtask

  task automatic wr_case(input int blc, input int ilv, input int sgl, input int st,
                         input int dqm_at, input string req);
    int lg = (blc <= 3) ? blc : 0;
    int len = sgl ? 1 : (1 << lg);
    bit ew;
    int ea;
    logic [DQ_W-1:0] din;
    set_mode(3, blc, ilv, sgl);
    for (int j = 0; j < 12; j++) begin
      din = 16'h5000 + 16'(j * 3 + st);
      cmd_wr = (j == 0); col_start = COL_W'(st); dq_in = din; dqm = (j == dqm_at);
      #2;
      ew = (j < len) && (j != dqm_at);
      ea = exp_addr(st, j, lg, 1'b0, ilv[0]);
      if (ew)
        chk(mem_we && mem_addr == COL_W'(ea) && mem_wdata == din, req,
            {6'd0, mem_we, mem_addr, mem_wdata}, {6'd0, 1'b1, 9'(ea), din});
      else
        chk(!mem_we, req, {31'd0, mem_we}, 32'd0);
      next();
      idle();
    end
  endtask

  // offsets: write commands and expected write addresses (-1 none)
  task automatic wr_seq(input int n, input int c0, input int c1, input int s0, input int s1,
                        input int stop_at, input int ea [8], input string req);
    for (int j = 0; j < n; j++) begin
      cmd_wr = (j == c0) || (j == c1);
      col_start = COL_W'((j == c1) ? s1 : s0);
      cmd_stop = (j == stop_at);
      dq_in = 16'h3000 + 16'(j);
      #2;
      if (ea[j] >= 0)
        chk(mem_we && mem_addr == COL_W'(ea[j]), req, {22'd0, mem_we, mem_addr}, {22'd0, 1'b1, 9'(ea[j])});
      else
        chk(!mem_we, req, {31'd0, mem_we}, 32'd0);
      next();
      idle();
    end
  endtask

  initial begin : main
    int starts [4] = '{0, 6, 13, 255};
    int ws [2] = '{3, 250};
    rst_n = 0; mode_cl = 2'd3; mode_bl = 3'd0; mode_ilv = 0; mode_single_wr = 0;
    col_start = '0;
    idle();
    init_mem();
    repeat (3) @(posedge clk);
    #3;
    chk(!dq_oe && dq_out == '0 && !mem_we, "R1 in reset", {15'd0, dq_oe, dq_out}, 32'd0);
    #1 rst_n = 1;
    #2;
    chk(!dq_oe && dq_out == '0 && !mem_we, "R1 after release", {15'd0, dq_oe, dq_out}, 32'd0);
    next();
    // default mode: latency 3, one beat
    rd_case(0, 3, 0, 0, 0, 7, -1, -1, -1, 0, "R1 R3 default mode");
    // sweep of latency, length, ordering and start column
    for (int c = 2; c <= 3; c++)
      for (int b = 0; b <= 3; b++)
        for (int v = 0; v <= 1; v++)
          for (int s = 0; s < 4; s++)
            rd_case(1, c, b, v, 0, starts[s], -1, -1, -1, 0, v ? "R2 R3 R8" : "R2 R3 R7");
    // reserved codes
    rd_case(1, 0, 5, 0, 0, 20, -1, -1, -1, 0, "R2 reserved codes");
    // full page wrap with stop, interleave flag ignored
    rd_case(1, 3, 7, 1, 0, 508, -1, 8, -1, 0, "R9 R10 full page");
    rd_case(1, 2, 7, 0, 0, 300, 4, 5, -1, 0, "R6 R9 R10 full page masked");
    // read mask on an in-flight beat
    rd_case(1, 2, 3, 0, 0, 0, 3, -1, -1, 0, "R6 R13 read mask");
    rd_case(1, 3, 3, 1, 0, 9, 6, -1, -1, 0, "R6 read mask latency 3");
    // truncation by a second read
    rd_case(1, 2, 2, 0, 0, 0, -1, -1, 2, 100, "R11 read cut off");
    rd_case(1, 3, 3, 0, 0, 40, -1, -1, 1, 77, "R11 back to back reads");
    // stop in mid read burst
    rd_case(1, 3, 3, 0, 0, 16, -1, 3, -1, 0, "R10 read stop");
    // writes
    for (int b = 0; b <= 3; b++)
      for (int v = 0; v <= 1; v++)
        for (int s = 0; s < 2; s++)
          for (int g = 0; g <= 1; g++)
            wr_case(b, v, g, ws[s], 1, g ? "R12 R5 single write" : "R4 R5 R7 R8 write");
    wr_case(2, 0, 0, 33, 0, "R5 mask on beat 0");
    set_mode(3, 2, 0, 0);
    wr_seq(4, 0, -1, 50, 0, 0, '{-1, -1, -1, -1, -1, -1, -1, -1}, "R10 stop beats write");
    set_mode(3, 3, 0, 0);
    wr_seq(6, 0, -1, 16, 0, 2, '{16, 17, -1, -1, -1, -1, -1, -1}, "R10 write stop");
    set_mode(3, 2, 0, 0);
    wr_seq(6, 0, 1, 8, 40, -1, '{8, 40, 41, 42, 43, -1, -1, -1}, "R11 back to back writes");
    // single-write mode leaves reads at full length
    init_mem();
    rd_case(1, 2, 2, 0, 1, 60, -1, -1, -1, 0, "R12 read in single write mode");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule